// File: doc/BRIEF.md
# Multiplexed Front-End Readout Sequencer

After a front end has captured an event on its held analog multiplexer, this block walks the multiplexer through its channels and turns each one into a digital word. It starts from a strobe that has already been synchronised to the system clock; the raw trigger never reaches it. For every step it drives the multiplexer clock, asks the external ADC for one conversion, and waits for that conversion to finish. It then forwards the word, tagged with a channel index, to a downstream buffer.

Two configuration bits shape the event, and both are read only at the start strobe. One adds a trailing dummy step, so that the multiplexer output is not left floating after the last real channel. That dummy conversion is taken but its word is dropped, so every event delivers exactly the same number of words to the buffer. The other bit chooses whether the multiplexer RESET pulse comes before HOLD is raised or after it.

The controller is a single Moore machine with these states:
- `ST_IDLE`: waits for a start.
- `ST_HOLD_FIRST`: raises HOLD one cycle ahead of RESET; used when RESET goes late.
- `ST_RESET_PRE`: RESET with HOLD low.
- `ST_RESET_POST`: RESET with HOLD high.
- `ST_MUXCLK`: multiplexer clock high.
- `ST_CONV`: convert request.
- `ST_WAIT_ADC`: waits for the ADC.
- `ST_DONE`: event-done pulse.

Its transitions are:
- From `ST_IDLE` on a start: to `ST_HOLD_FIRST` when RESET goes late, otherwise to `ST_RESET_PRE`.
- `ST_HOLD_FIRST` to `ST_RESET_POST` after one cycle.
- Either RESET state to `ST_MUXCLK` once its timer expires.
- `ST_MUXCLK` to `ST_CONV` once its timer expires.
- `ST_CONV` to `ST_WAIT_ADC` after one cycle.
- `ST_WAIT_ADC`, on ADC valid, to `ST_DONE` after the last step and to `ST_MUXCLK` otherwise.
- `ST_DONE` to `ST_IDLE` after one cycle.

Top module: `mux_readout_seq`

## Requirements
- R1: During and directly after reset, every output is low and the block is idle.
- R2: With `cfg_reset_late_i`=0 at start, `mux_reset_o` is high for RST_CYC cycles with `hold_o` low, and `hold_o` rises in the same cycle that `mux_reset_o` falls.
- R3: With `cfg_reset_late_i`=1 at start, `hold_o` rises one cycle before `mux_reset_o`, and `mux_reset_o` is then high for RST_CYC cycles with `hold_o` high.
- R4: Each step holds `mux_clk_o` high for MUXCLK_CYC consecutive cycles and then `adc_conv_o` for exactly one cycle. The next step does not begin until `adc_valid_i` has been seen after the convert.
- R5: An event has NUM_CH steps (18 by default) when `cfg_extra_read_i`=0, and NUM_CH+1 steps when it is 1.
- R6: `smp_valid_o` pulses exactly NUM_CH times per event, one cycle after the accepted `adc_valid_i`. The pulses carry `smp_idx_o` from 0 up to NUM_CH-1 in order, and `smp_data_o` equal to the ADC word of that step.
- R7: The conversion of the dummy step (step index NUM_CH) produces no `smp_valid_o`.
- R8: `evt_done_o` pulses for one cycle, in the cycle after the final step's `adc_valid_i`. `hold_o` is low from then on and the block is idle.
- R9: A start strobe that arrives while an event is running is ignored; no second event follows.
- R10: Both configuration bits are sampled at the start strobe; changing them during an event has no effect on that event.
- R11: `adc_valid_i` is ignored outside `ST_WAIT_ADC`, so it produces no sample and no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clock-synchronised transfer-start strobe |
| cfg_extra_read_i | input | 1 | 1 adds a dummy trailing step whose word is dropped |
| cfg_reset_late_i | input | 1 | 1 issues RESET after HOLD, 0 issues it before HOLD |
| adc_data_i | input | DATA_W | Conversion result |
| adc_valid_i | input | 1 | Conversion result is valid |
| mux_clk_o | output | 1 | Multiplexer step clock |
| mux_reset_o | output | 1 | Multiplexer RESET pulse |
| hold_o | output | 1 | HOLD level, high for the held part of the event |
| adc_conv_o | output | 1 | One-cycle convert request |
| smp_data_o | output | DATA_W | Forwarded sample word |
| smp_valid_o | output | 1 | Sample word valid (kept samples only) |
| smp_idx_o | output | IDX_W | Channel index of the sample |
| evt_done_o | output | 1 | One-cycle end-of-event pulse |

## Verification
The main function is run over a table of events that covers every combination of the dummy-step bit and the RESET ordering bit. The ADC latencies range from one to six cycles, and the data seeds include one that wraps the word width. The combination of the two bits tells apart step counts of 18 and 19, and shows whether the dummy word is dropped. The ordering flags tell apart RESET with HOLD low from RESET with HOLD high. The long latencies show that the sequencer waits for the ADC instead of stepping on a fixed cadence. Directed cases then check four more behaviours: a second start during an event, configuration flips in mid-event, a stray ADC valid while idle, and the output levels during reset.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD_FIRST,
        ST_RESET_PRE,
        ST_RESET_POST,
        ST_MUXCLK,
        ST_CONV,
        ST_WAIT_ADC,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/mrs_timer.sv
module mrs_timer #(
    parameter int TMR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TMR_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/mrs_step_ctr.sv
module mrs_step_ctr #(
    parameter int STEP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    input  logic [STEP_W-1:0] n_steps_i,
    output logic [STEP_W-1:0] step_o,
    output logic              last_o
);

    logic [STEP_W-1:0] step_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (clr_i) begin
            step_q <= '0;
        end else if (inc_i) begin
            step_q <= step_q + 1'b1;
        end
    end

    assign step_o = step_q;
    assign last_o = (step_q == n_steps_i - 1'b1);

endmodule

// File: rtl/mux_readout_seq.sv
module mux_readout_seq
    import mrs_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int NUM_CH     = 18,
    parameter int MUXCLK_CYC = 2,
    parameter int RST_CYC    = 3,
    parameter int IDX_W      = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cfg_extra_read_i,
    input  logic              cfg_reset_late_i,
    input  logic [DATA_W-1:0] adc_data_i,
    input  logic              adc_valid_i,
    output logic              mux_clk_o,
    output logic              mux_reset_o,
    output logic              hold_o,
    output logic              adc_conv_o,
    output logic [DATA_W-1:0] smp_data_o,
    output logic              smp_valid_o,
    output logic [IDX_W-1:0]  smp_idx_o,
    output logic              evt_done_o
);

    localparam int STEP_W  = $clog2(NUM_CH + 2);
    localparam int MAX_CYC = (RST_CYC > MUXCLK_CYC) ? RST_CYC : MUXCLK_CYC;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);
    localparam logic [STEP_W-1:0] KEEP_LIM   = STEP_W'(NUM_CH);
    localparam logic [STEP_W-1:0] STEPS_BASE = STEP_W'(NUM_CH);
    localparam logic [STEP_W-1:0] STEPS_EXT  = STEP_W'(NUM_CH + 1);

    seq_state_e        state_q, state_d;
    logic              extra_q;
    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic [STEP_W-1:0] step, n_steps;
    logic              step_last, step_clr, step_inc, accept;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    logic [IDX_W-1:0]  idx_q;

    // Configuration capture at the start strobe (R10)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            extra_q <= 1'b0;
        end else if (state_q == ST_IDLE && start_i) begin
            extra_q <= cfg_extra_read_i;
        end
    end

    assign n_steps = extra_q ? STEPS_EXT : STEPS_BASE;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start_i) state_d = cfg_reset_late_i ? ST_HOLD_FIRST : ST_RESET_PRE;
            ST_HOLD_FIRST: state_d = ST_RESET_POST;
            ST_RESET_PRE:  if (tmr_zero) state_d = ST_MUXCLK;
            ST_RESET_POST: if (tmr_zero) state_d = ST_MUXCLK;
            ST_MUXCLK:     if (tmr_zero) state_d = ST_CONV;
            ST_CONV:       state_d = ST_WAIT_ADC;
            ST_WAIT_ADC:   if (adc_valid_i) state_d = step_last ? ST_DONE : ST_MUXCLK;
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        mux_clk_o   = 1'b0;
        mux_reset_o = 1'b0;
        hold_o      = 1'b0;
        adc_conv_o  = 1'b0;
        evt_done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:       ;
            ST_HOLD_FIRST: hold_o = 1'b1;
            ST_RESET_PRE:  mux_reset_o = 1'b1;
            ST_RESET_POST: begin mux_reset_o = 1'b1; hold_o = 1'b1; end
            ST_MUXCLK:     begin mux_clk_o = 1'b1; hold_o = 1'b1; end
            ST_CONV:       begin adc_conv_o = 1'b1; hold_o = 1'b1; end
            ST_WAIT_ADC:   hold_o = 1'b1;
            ST_DONE:       evt_done_o = 1'b1;
            default:       ;
        endcase
    end

    // Dwell timer: loaded on every state change
    always_comb begin
        unique case (state_d)
            ST_RESET_PRE, ST_RESET_POST: tmr_val = TMR_W'(RST_CYC - 1);
            ST_MUXCLK:                   tmr_val = TMR_W'(MUXCLK_CYC - 1);
            default:                     tmr_val = '0;
        endcase
    end

    assign tmr_load = (state_d != state_q);

    mrs_timer #(.TMR_W(TMR_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    assign accept   = (state_q == ST_WAIT_ADC) && adc_valid_i;
    assign step_clr = (state_q == ST_IDLE);
    assign step_inc = accept;

    mrs_step_ctr #(.STEP_W(STEP_W)) steps_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (step_clr),
        .inc_i     (step_inc),
        .n_steps_i (n_steps),
        .step_o    (step),
        .last_o    (step_last)
    );

    // Sample forwarding; the dummy step is masked (R7)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
            idx_q   <= '0;
        end else begin
            valid_q <= 1'b0;
            if (accept && step < KEEP_LIM) begin
                valid_q <= 1'b1;
                data_q  <= adc_data_i;
                idx_q   <= IDX_W'(step);
            end
        end
    end

    assign smp_valid_o = valid_q;
    assign smp_data_o  = data_q;
    assign smp_idx_o   = idx_q;

endmodule

// File: rtl/mrs_checker.sv
module mrs_checker #(
    parameter int NUM_CH = 18,
    parameter int IDX_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adc_valid_i,
    input logic             mux_clk_o,
    input logic             mux_reset_o,
    input logic             hold_o,
    input logic             adc_conv_o,
    input logic             smp_valid_o,
    input logic [IDX_W-1:0] smp_idx_o,
    input logic             evt_done_o
);

    p_conv_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_conv_o |=> !adc_conv_o);

    p_conv_not_with_mux_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_conv_o && mux_clk_o));

    p_hold_at_reset_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mux_reset_o) |-> hold_o);

    p_hold_leads_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mux_reset_o) && hold_o) |-> $past(hold_o));

    p_valid_after_adc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> $past(adc_valid_i));

    p_idx_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> (int'(smp_idx_o) < NUM_CH));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done_o |=> (!evt_done_o && !hold_o));

    p_no_step_unheld_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_o |-> (!mux_clk_o && !adc_conv_o));

endmodule

bind mux_readout_seq mrs_checker #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_valid_i (adc_valid_i),
    .mux_clk_o   (mux_clk_o),
    .mux_reset_o (mux_reset_o),
    .hold_o      (hold_o),
    .adc_conv_o  (adc_conv_o),
    .smp_valid_o (smp_valid_o),
    .smp_idx_o   (smp_idx_o),
    .evt_done_o  (evt_done_o)
);

// File: tb/mux_readout_seq_tb_top.sv
`timescale 1ns/1ps
module mux_readout_seq_tb_top;

    localparam int DATA_W     = 12;
    localparam int NUM_CH     = 18;
    localparam int MUXCLK_CYC = 2;
    localparam int RST_CYC    = 3;
    localparam int IDX_W      = $clog2(NUM_CH);
    localparam int NVEC       = 6;
    // {extra, late, adc latency[3:0], seed[11:0]}
    localparam logic [17:0] VECS [NVEC] = '{
        {1'b0, 1'b0, 4'd1, 12'h100},
        {1'b1, 1'b0, 4'd1, 12'h3F0},
        {1'b0, 1'b1, 4'd3, 12'h005},
        {1'b1, 1'b1, 4'd2, 12'hFF0},
        {1'b1, 1'b0, 4'd6, 12'h800},
        {1'b0, 1'b1, 4'd4, 12'hABC}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic cfg_extra_read_i = 1'b0;
    logic cfg_reset_late_i = 1'b0;
    logic [DATA_W-1:0] adc_data_i = '0;
    logic adc_valid_i = 1'b0;
    logic mux_clk_o, mux_reset_o, hold_o, adc_conv_o, smp_valid_o, evt_done_o;
    logic [DATA_W-1:0] smp_data_o;
    logic [IDX_W-1:0] smp_idx_o;

    always #2.5 clk = ~clk;

    mux_readout_seq #(
        .DATA_W(DATA_W), .NUM_CH(NUM_CH), .MUXCLK_CYC(MUXCLK_CYC), .RST_CYC(RST_CYC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cfg_extra_read_i(cfg_extra_read_i), .cfg_reset_late_i(cfg_reset_late_i),
        .adc_data_i(adc_data_i), .adc_valid_i(adc_valid_i),
        .mux_clk_o(mux_clk_o), .mux_reset_o(mux_reset_o), .hold_o(hold_o),
        .adc_conv_o(adc_conv_o), .smp_data_o(smp_data_o), .smp_valid_o(smp_valid_o),
        .smp_idx_o(smp_idx_o), .evt_done_o(evt_done_o)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ADC model
    int adc_lat = 1;
    int adc_seed = 0;
    int adc_k = 0;
    bit adc_pend = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (adc_conv_o) begin
                adc_pend = 1;
                repeat (adc_lat) @(negedge clk);
                adc_data_i  = DATA_W'(adc_seed + 7 * adc_k);
                adc_valid_i = 1'b1;
                adc_pend    = 0;
                adc_k++;
                @(negedge clk);
                adc_valid_i = 1'b0;
            end
        end
    end

    // Output monitor
    bit mon_clr = 0;
    int mon_mux, mon_conv, mon_valid, mon_bad_data, mon_done, mon_rst_cyc;
    int mon_bad_run, mon_wait_viol, mux_run;
    bit mon_rst_nohold, mon_rst_hold, mon_hold_first, mon_rst_seen, mux_prev;

    always @(negedge clk) begin
        if (mon_clr) begin
            mon_mux = 0; mon_conv = 0; mon_valid = 0; mon_bad_data = 0; mon_done = 0;
            mon_rst_cyc = 0; mon_bad_run = 0; mon_wait_viol = 0; mux_run = 0;
            mon_rst_nohold = 0; mon_rst_hold = 0; mon_hold_first = 0; mon_rst_seen = 0;
            mux_prev = 0;
        end else begin
            if (mux_clk_o && !mux_prev) mon_mux++;
            if (mux_clk_o) mux_run++;
            if (!mux_clk_o && mux_prev) begin
                if (mux_run != MUXCLK_CYC) mon_bad_run++;
                mux_run = 0;
            end
            mux_prev = mux_clk_o;
            if (adc_conv_o) mon_conv++;
            if (mux_clk_o && adc_pend) mon_wait_viol++;
            if (hold_o && !mon_rst_seen) mon_hold_first = 1;
            if (mux_reset_o) begin
                mon_rst_seen = 1;
                mon_rst_cyc++;
                if (hold_o) mon_rst_hold = 1; else mon_rst_nohold = 1;
            end
            if (smp_valid_o) begin
                if (int'(smp_idx_o) != mon_valid ||
                    smp_data_o != DATA_W'(adc_seed + 7 * mon_valid)) mon_bad_data++;
                mon_valid++;
            end
            if (evt_done_o) mon_done++;
        end
    end

    task automatic clear_mon();
        mon_clr = 1;
        @(negedge clk);
        @(negedge clk);
        mon_clr = 0;
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (mon_done == 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic prep(input bit extra, input bit late, input int lat, input int seed);
        cfg_extra_read_i = extra;
        cfg_reset_late_i = late;
        adc_lat  = lat;
        adc_seed = seed;
        adc_k    = 0;
        clear_mon();
    endtask

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(!mux_clk_o && !mux_reset_o && !hold_o && !adc_conv_o && !smp_valid_o && !evt_done_o,
            "R1 outputs in reset", int'({mux_clk_o, mux_reset_o, hold_o, adc_conv_o, smp_valid_o, evt_done_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!hold_o && !mux_clk_o && !evt_done_o, "R1 idle after reset",
            int'({hold_o, mux_clk_o, evt_done_o}), 0);

        // Table-driven events
        for (int v = 0; v < NVEC; v++) begin
            bit extra = VECS[v][17];
            bit late  = VECS[v][16];
            int steps = extra ? NUM_CH + 1 : NUM_CH;
            prep(extra, late, int'(VECS[v][15:12]), int'(VECS[v][11:0]));
            pulse_start();
            wait_done();
            chk(mon_mux == steps, "R5 step count", mon_mux, steps);
            chk(mon_conv == steps, "R4 convert pulses", mon_conv, steps);
            chk(mon_bad_run == 0, "R4 mux clock width", mon_bad_run, 0);
            chk(mon_wait_viol == 0, "R4 wait for ADC", mon_wait_viol, 0);
            chk(mon_valid == NUM_CH, "R7 kept sample count", mon_valid, NUM_CH);
            chk(mon_bad_data == 0, "R6 index/data", mon_bad_data, 0);
            chk(mon_done == 1, "R8 done pulse", mon_done, 1);
            chk(!hold_o, "R8 hold low after done", int'(hold_o), 0);
            chk(mon_rst_cyc == RST_CYC, "R2/R3 reset length", mon_rst_cyc, RST_CYC);
            if (late) begin
                chk(mon_rst_hold && !mon_rst_nohold && mon_hold_first, "R3 reset after hold",
                    int'({mon_rst_hold, mon_rst_nohold, mon_hold_first}), 5);
            end else begin
                chk(!mon_rst_hold && mon_rst_nohold && !mon_hold_first, "R2 reset before hold",
                    int'({mon_rst_hold, mon_rst_nohold, mon_hold_first}), 2);
            end
        end

        // R9: start while busy
        prep(1'b0, 1'b0, 2, 12'h040);
        pulse_start();
        repeat (15) @(negedge clk);
        pulse_start();
        wait_done();
        repeat (60) @(negedge clk);
        chk(mon_mux == NUM_CH, "R9 busy start steps", mon_mux, NUM_CH);
        chk(mon_done == 1, "R9 busy start done count", mon_done, 1);

        // R10: config change mid-event
        prep(1'b0, 1'b0, 1, 12'h222);
        pulse_start();
        repeat (10) @(negedge clk);
        cfg_extra_read_i = 1'b1;
        cfg_reset_late_i = 1'b1;
        wait_done();
        chk(mon_mux == NUM_CH, "R10 latched step count", mon_mux, NUM_CH);
        chk(mon_valid == NUM_CH && mon_bad_data == 0, "R10 samples", mon_valid, NUM_CH);
        chk(!mon_rst_hold, "R10 latched ordering", int'(mon_rst_hold), 0);

        // R11: stray ADC valid while idle
        prep(1'b0, 1'b0, 1, 0);
        adc_valid_i = 1'b1;
        repeat (2) @(negedge clk);
        adc_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(mon_valid == 0, "R11 no sample from stray valid", mon_valid, 0);
        chk(mon_mux == 0 && mon_done == 0, "R11 no step from stray valid", mon_mux + mon_done, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule